// File: doc/BRIEF.md
# Synchronous Half-Duplex Programming-Link Transceiver

This block is the bit-level engine of a two-wire synchronous link that programs a device. It produces the link clock from a free-running programmable divider. It shares one data wire between the host and the device, so it either drives that wire or listens to it. On request it serializes a byte, or a break, into a 12-bit frame. On another request it waits for a frame from the device, deserializes it and checks its parity.

The host drives data on the falling link-clock edge and samples on the rising edge. When receiving, the engine does not know when the device will answer. It therefore keeps the clock running and stays at the frame-start position until the line goes low. A single `busy` output guards the engine. A new request is taken only while it is low. When several requests arrive in the same cycle, send wins over break, and break wins over receive.

Top module: `prog_link_xcvr`

## Requirements
- R1: A sent byte appears on `dq_out` as 12 bits, one per link-clock period, in this order: a low start bit, data bits 0 through 7, an even-parity bit (the XOR of the data), then two high stop bits.
- R2: `link_clk` is low at reset and toggles once every DIV_RELOAD+1 system clocks, so one link-clock period lasts 2*(DIV_RELOAD+1) system clocks.
- R3: `dq_out` changes only in the cycle where `link_clk` falls. It is high whenever no frame is being shifted out, including after an accepted request and before the first falling edge.
- R4: In receive mode `dq_in` is sampled only at rising `link_clk` edges. Its value at other times has no effect on the received byte.
- R5: In receive mode, each rising edge that sees `dq_in` high at the frame-start position is skipped. Reception starts at the first rising edge that sees it low.
- R6: After the 12th received bit, `rx_data` holds the eight data bits (the first data bit in bit 0). `rx_valid` pulses for exactly one cycle, and `busy` falls in that same cycle.
- R7: `parity_err` is updated with each `rx_valid`. It is 1 when the received parity bit differs from the XOR of the received data bits, and 0 otherwise.
- R8: A break request drives `dq_out` high, with `dq_oe` high, for a full 12-bit frame.
- R9: `busy` is high from the cycle after an accepted request until the frame ends. Send, break or receive requests made while `busy` is high are ignored.
- R10: `dq_oe` goes low in the cycle after a receive request is accepted, before the first sampling edge. It stays low until a send or break request is accepted, which sets it high.
- R11: During reset, `link_clk` is 0, `dq_out` is 1, `dq_oe` is 1, and `busy` and `rx_valid` are 0.
- R12: Requests made in the same cycle are served in priority order: send first, then break, then receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| send_req | input | 1 | Request to send `send_data` |
| send_data | input | 8 | Byte to send |
| break_req | input | 1 | Request to send a break frame |
| recv_req | input | 1 | Request to receive one frame |
| dq_in | input | 1 | Data wire as seen at the pin |
| link_clk | output | 1 | Link clock to the device |
| dq_out | output | 1 | Value driven on the data wire |
| dq_oe | output | 1 | Drive enable for the data wire |
| busy | output | 1 | A frame is in progress |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle strobe: `rx_data` is new |
| parity_err | output | 1 | Parity mismatch on the last received byte |

## Verification
The bench acts as the device. It captures `dq_out` on rising link-clock edges and drives `dq_in` on falling edges.

Several mistakes would show up directly at the ports:
- A transmitter that updates on the wrong edge would trip the edge monitor.
- A transmitter that drives the start bit right after acceptance would show a frame shifted by half a period.
- A receiver that does not wait for the start bit would return garbage when the device answers late.

The bench toggles `dq_in` between sampling edges. A receiver that also samples on falling edges would therefore return wrong bytes.

Frames with a flipped parity bit check the error flag. A request injected in mid-frame checks that busy requests are ignored. A design that accepted it would corrupt the frame or drop `dq_oe`.

// File: rtl/plx_pkg.sv
// Shared frame constants and helpers for the programming-link transceiver.
// Assumes a fixed frame: start, data, parity, two stops.
package plx_pkg;
    localparam int DATA_BITS  = 8;
    localparam int STOP_BITS  = 2;
    localparam int FRAME_BITS = 1 + DATA_BITS + 1 + STOP_BITS;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    typedef logic [FRAME_BITS-1:0] frame_t;

    // Frame in shift order, bit 0 leaves first.
    function automatic frame_t build_frame(input logic [DATA_BITS-1:0] d);
        return {{STOP_BITS{1'b1}}, ^d, d, 1'b0};
    endfunction

    localparam frame_t BREAK_FRAME = '1;
endpackage

// File: rtl/plx_tick_gen.sv
// Free-running link clock divider.
// One tick every RELOAD+1 system clocks; the link clock toggles on every tick.
// It marks which tick makes a rising edge and which makes a falling edge.
module plx_tick_gen #(
    parameter int RELOAD = 80
) (
    input  logic clk,
    input  logic rst_n,
    output logic link_clk,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (RELOAD < 1) ? 1 : $clog2(RELOAD + 1);

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick      = (cnt == '0);
    assign rise_tick = tick & ~link_clk;
    assign fall_tick = tick &  link_clk;

    // Down-counter that reloads on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= CW'(RELOAD);
        else if (tick) cnt <= CW'(RELOAD);
        else           cnt <= cnt - 1'b1;
    end

    // Link clock flips on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    link_clk <= 1'b0;
        else if (tick) link_clk <= ~link_clk;
    end

    AST_CLK_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(link_clk)); // R2
endmodule

// File: rtl/plx_tx_ser.sv
// Transmit shifter: sends one frame LSB first, one bit per falling tick.
// Holds the line high while idle. It releases `active` one falling tick after
// the last bit, so the final stop bit lasts a full link period.
module plx_tx_ser
    import plx_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  frame_t frame_in,
    input  logic   fall_tick,
    output logic   dq_out,
    output logic   active
);
    frame_t           sh;
    logic [CNT_W-1:0] left;

    // Load on start, then shift one bit out at each falling tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            left   <= '0;
            sh     <= '1;
            dq_out <= 1'b1;
        end else if (start) begin
            active <= 1'b1;
            left   <= CNT_W'(FRAME_BITS);
            sh     <= frame_in;
        end else if (active && fall_tick) begin
            if (left != '0) begin
                dq_out <= sh[0];
                sh     <= {1'b1, sh[FRAME_BITS-1:1]};
                left   <= left - 1'b1;
            end else begin
                active <= 1'b0;
            end
        end
    end

    AST_TX_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_tick |=> $stable(dq_out)); // R3
    AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> dq_out); // R3
endmodule

// File: rtl/plx_rx_deser.sv
// Receive shifter: samples the line at rising ticks and waits at the frame
// start while the line is high. Bits enter from the top, so after a full
// frame the start bit has dropped out and the data sits in the low bits.
module plx_rx_deser
    import plx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 rise_tick,
    input  logic                 dq_in,
    output logic [DATA_BITS-1:0] data,
    output logic                 valid,
    output logic                 perr,
    output logic                 active
);
    frame_t           sh;
    frame_t           sh_nx;
    logic [CNT_W-1:0] left;
    logic             hunting;

    assign sh_nx   = {1'b0, dq_in, sh[FRAME_BITS-2:1]};
    assign hunting = (left == CNT_W'(FRAME_BITS)) && dq_in;

    // Sample at rising ticks; publish byte and parity result after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            left   <= '0;
            sh     <= '0;
            data   <= '0;
            valid  <= 1'b0;
            perr   <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (start) begin
                active <= 1'b1;
                left   <= CNT_W'(FRAME_BITS);
                sh     <= '0;
            end else if (active && rise_tick && !hunting) begin
                sh   <= sh_nx;
                left <= left - 1'b1;
                if (left == CNT_W'(1)) begin
                    active <= 1'b0;
                    valid  <= 1'b1;
                    data   <= sh_nx[DATA_BITS-1:0];
                    perr   <= ^sh_nx[DATA_BITS:0];
                end
            end
        end
    end

    AST_RX_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_tick && !start) |=> $stable(sh)); // R4
    AST_RX_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !start && rise_tick && dq_in && left == CNT_W'(FRAME_BITS))
        |=> (left == CNT_W'(FRAME_BITS))); // R5
    AST_RX_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid); // R6
endmodule

// File: rtl/prog_link_xcvr.sv
// Top of the half-duplex programming-link transceiver. It arbitrates requests
// (send, then break, then receive), owns the data-pin drive enable, and ties
// the divider to the two shifters. Assumes the pin logic outside merges
// dq_out/dq_oe and returns the wire on dq_in.
module prog_link_xcvr
    import plx_pkg::*;
#(
    parameter int DIV_RELOAD = 80
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 send_req,
    input  logic [DATA_BITS-1:0] send_data,
    input  logic                 break_req,
    input  logic                 recv_req,
    input  logic                 dq_in,
    output logic                 link_clk,
    output logic                 dq_out,
    output logic                 dq_oe,
    output logic                 busy,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 parity_err
);
    logic   rise_tick, fall_tick;
    logic   tx_active, rx_active;
    logic   go_send, go_break, go_recv;
    frame_t tx_frame;

    assign busy     = tx_active | rx_active;
    assign go_send  = send_req & ~busy;
    assign go_break = break_req & ~busy & ~send_req;
    assign go_recv  = recv_req & ~busy & ~send_req & ~break_req;

    // Choose the frame to load: data frame for send, all-high for break.
    always_comb begin
        tx_frame = go_send ? build_frame(send_data) : BREAK_FRAME;
    end

    // Pin ownership: take the wire for sending, release it for receiving.
    always_ff @(posedge clk) begin
        if (!rst_n)                   dq_oe <= 1'b1;
        else if (go_send || go_break) dq_oe <= 1'b1;
        else if (go_recv)             dq_oe <= 1'b0;
    end

    plx_tick_gen #(.RELOAD(DIV_RELOAD)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_clk  (link_clk),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    plx_tx_ser u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (go_send | go_break),
        .frame_in  (tx_frame),
        .fall_tick (fall_tick),
        .dq_out    (dq_out),
        .active    (tx_active)
    );

    plx_rx_deser u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (go_recv),
        .rise_tick (rise_tick),
        .dq_in     (dq_in),
        .data      (rx_data),
        .valid     (rx_valid),
        .perr      (parity_err),
        .active    (rx_active)
    );

    AST_OE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_active |-> !dq_oe); // R10
    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_active && rx_active)); // R9
    AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && recv_req) |=> dq_oe); // R9
    AST_VALID_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !busy); // R6
endmodule

// File: tb/prog_link_xcvr_test.sv
module prog_link_xcvr_test;
    localparam int RELOAD = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       send_req = 1'b0, break_req = 1'b0, recv_req = 1'b0;
    logic [7:0] send_data = 8'h00;
    logic       dq_in = 1'b1;
    logic       link_clk, dq_out, dq_oe, busy, rx_valid, parity_err;
    logic [7:0] rx_data;

    int errors = 0;
    int checks = 0;
    logic lc_prev, dq_prev;
    bit   mon_en = 0;

    // Vector: [12] wiggle line between edges, [11] receive, [10] flip parity,
    // [9:8] idle periods before start, [7:0] data
    localparam logic [12:0] VEC [8] = '{
        13'h00A5, 13'h0000, 13'h00FF, 13'h0001,
        13'h083C, 13'h1B81, 13'h0C7E, 13'h1DFF
    };

    prog_link_xcvr #(.DIV_RELOAD(RELOAD)) uut (
        .clk(clk), .rst_n(rst_n), .send_req(send_req), .send_data(send_data),
        .break_req(break_req), .recv_req(recv_req), .dq_in(dq_in),
        .link_clk(link_clk), .dq_out(dq_out), .dq_oe(dq_oe), .busy(busy),
        .rx_data(rx_data), .rx_valid(rx_valid), .parity_err(parity_err)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance to the next negedge; flag dq_out changes away from falling link edges (R3).
    task automatic step();
        lc_prev = link_clk;
        dq_prev = dq_out;
        @(negedge clk);
        if (mon_en && dq_out !== dq_prev)
            chk(lc_prev && !link_clk, "R3 dq_out changed off falling edge", {31'd0, link_clk}, 0);
    endtask

    // mode 0 send, 1 break, 2 all requests at once, 3 break+receive
    task automatic run_tx(input logic [7:0] b, input int mode, input bit poke, input string tag);
        logic [11:0] exp, got;
        int rises, guard;
        bit seen_fall, oe_bad;
        exp = (mode == 1 || mode == 3) ? 12'hFFF : {2'b11, ^b, b, 1'b0};
        send_data = b;
        send_req  = (mode == 0 || mode == 2);
        break_req = (mode != 0);
        recv_req  = (mode >= 2);
        step();
        send_req = 0; break_req = 0; recv_req = 0;
        chk(busy === 1'b1, "R9 busy after accept", {31'd0, busy}, 1);
        chk(dq_out === 1'b1, "R3 idle high before first fall", {31'd0, dq_out}, 1);
        rises = 0; guard = 0; seen_fall = 0; oe_bad = 0; got = '0;
        while (busy && guard < 1000) begin
            step();
            guard++;
            if (lc_prev && !link_clk) seen_fall = 1;
            if (!lc_prev && link_clk && seen_fall && busy) begin
                if (rises < 12) got[rises] = dq_out;
                rises++;
                if (!dq_oe) oe_bad = 1;
                if (poke && rises == 3) begin
                    send_data = ~b; send_req = 1; recv_req = 1; break_req = 1;
                    step();
                    send_req = 0; recv_req = 0; break_req = 0;
                end
            end
        end
        chk(rises == 12, {tag, " bit periods"}, rises, 12);
        chk(got === exp, {tag, " frame"}, {20'd0, got}, {20'd0, exp});
        chk(!oe_bad && dq_oe === 1'b1, {tag, " R10 dq_oe held"}, {31'd0, dq_oe}, 1);
    endtask

    task automatic run_rx(input logic [7:0] b, input bit badp, input int idle, input bit wig, input string tag);
        logic [11:0] fr;
        int pos, guard;
        bit got;
        fr = {2'b11, (^b) ^ badp, b, 1'b0};
        dq_in = 1'b1;
        recv_req = 1;
        step();
        recv_req = 0;
        chk(dq_oe === 1'b0 && busy === 1'b1, "R10 oe released on receive accept", {30'd0, dq_oe, busy}, 1);
        pos = -idle; got = 0; guard = 0;
        while (!got && guard < 2000) begin
            step();
            guard++;
            if (rx_valid) begin
                got = 1;
                chk(rx_data === b, {tag, " R6 data"}, {24'd0, rx_data}, {24'd0, b});
                chk(parity_err === badp, {tag, " R7 parity_err"}, {31'd0, parity_err}, {31'd0, badp});
                chk(busy === 1'b0, {tag, " R6 busy falls with valid"}, {31'd0, busy}, 0);
            end else if (lc_prev && !link_clk) begin
                if (pos >= 0 && pos < 12) dq_in = fr[pos];
                pos++;
            end else if (wig && !lc_prev && link_clk && pos > 0) begin
                dq_in = ~dq_in;  // R4: junk between rising and next falling edge
            end
        end
        chk(got, {tag, " R5 frame received"}, {31'd0, got}, 1);
        step();
        chk(rx_valid === 1'b0, {tag, " R6 single pulse"}, {31'd0, rx_valid}, 0);
        chk(dq_oe === 1'b0, {tag, " R10 oe stays low"}, {31'd0, dq_oe}, 0);
        dq_in = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R11: reset values, held over several cycles
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i == 5)
                chk(link_clk === 0 && dq_out === 1 && dq_oe === 1 && busy === 0 && rx_valid === 0,
                    "R11 reset state", {27'd0, link_clk, dq_out, dq_oe, busy, rx_valid}, 5'b01100);
        end
        rst_n = 1'b1;
        step();
        mon_en = 1;

        // R2: spacing between link clock toggles
        n = 0;
        while (!(lc_prev != link_clk)) step();
        step(); n = 1;
        while (lc_prev == link_clk && n < 100) begin step(); n++; end
        chk(n == RELOAD + 1, "R2 toggle spacing", n, RELOAD + 1);

        // Table walk: R1 send frames, R5/R6/R7/R4 receive frames
        for (int v = 0; v < 8; v++) begin
            if (VEC[v][11])
                run_rx(VEC[v][7:0], VEC[v][10], int'(VEC[v][9:8]), VEC[v][12], $sformatf("R6 rx vec%0d", v));
            else
                run_tx(VEC[v][7:0], 0, 0, $sformatf("R1 tx vec%0d", v));
        end

        // R8: break frame
        run_tx(8'h00, 1, 0, "R8 break");
        // R9: requests during a busy send are ignored
        run_tx(8'hC3, 0, 1, "R9 ignore while busy");
        // R12: send beats break and receive; break beats receive
        run_tx(8'h5A, 2, 0, "R12 send priority");
        run_tx(8'h00, 3, 0, "R12 break over receive");
        // Turnaround after send, then send again after receive
        run_rx(8'h96, 0, 2, 1, "R4 rx after send");
        run_tx(8'h69, 0, 0, "R10 send after receive");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule